// File: doc/BRIEF.md
# Reset and Power-Fail Supervisor

This block drives the reset and warning outputs of a power-management device. It watches an LDO power-good flag, a core-in-regulation flag, a low-input-voltage comparator and an over-temperature warning. It also takes three raw contact inputs: a push-button (active high), a hot-reset button (active low) and a battery-cover switch (high while the cover is closed). Each contact input passes through a two-flop synchronizer and then a tick-paced debouncer before any logic acts on it.

The outputs are linked to each other. The power-on reset gates both the processor reset and the power-fail flag. A hot-reset press produces a timed processor-reset pulse, but only while the core rail is in regulation. Opening the battery cover raises the power-fail warning and an interrupt, and it latches a shutdown request for the main and core converters, with the LDOs moved to low-power mode. A push-button press also raises an interrupt. Each interrupt source has a mask bit and a sticky status bit that a write-one-to-clear pulse resets.

Top module: `pwr_reset_sup`

## Requirements
- R1: `por_n` is low in the cycle after `ldo_good` is sampled low. It goes high once `ldo_good` has been sampled high on POR_DLY consecutive clock edges.
- R2: `cpu_rst_n` is low in every cycle in which `por_n` is low.
- R3: A debounced falling edge of `hot_rst_n_raw`, taken while `core_in_reg` is high, drives `cpu_rst_n` low for exactly RST_PULSE cycles. The pulse starts DB_TICKS+3 clock edges after the raw change (ticks every cycle).
- R4: A debounced hot-reset falling edge that arrives while `core_in_reg` is low does not pull `cpu_rst_n` low.
- R5: `pwr_fail_n` is low whenever `vin_low` is high, `overtemp_warn` is high, the debounced cover level is low, or `por_n` is low. Otherwise it is high.
- R6: A debouncer accepts a new level only after DB_TICKS consecutive `sample_tick` samples of the synchronized input at that new level. Shorter pulses are ignored, and no level changes while `sample_tick` is low.
- R7: A debounced rising edge of `btn_raw` sets `irq_status[0]`. A debounced falling edge of `cover_raw` sets `irq_status[1]`. The opposite edges set nothing.
- R8: `irq` is high when any status bit is set whose bit in `irq_mask` is 0. A masked source still sets its status bit.
- R9: A 1 in `irq_clear[k]` clears `irq_status[k]` at the next edge. If a set event arrives in the same cycle, the set wins.
- R10: A debounced falling edge of `cover_raw` sets `shutdown_req`. Only `rst_n` clears it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | Debounce sample strobe |
| ldo_good | input | 1 | LDO output in regulation |
| core_in_reg | input | 1 | Core rail in regulation |
| vin_low | input | 1 | Input voltage below threshold |
| overtemp_warn | input | 1 | Over-temperature shutdown imminent |
| btn_raw | input | 1 | Raw push-button, active high |
| hot_rst_n_raw | input | 1 | Raw hot-reset button, active low |
| cover_raw | input | 1 | Raw battery-cover switch, high when closed |
| irq_mask | input | 2 | Interrupt masks: bit0 button, bit1 cover |
| irq_clear | input | 2 | Write-one-to-clear pulses for the status bits |
| por_n | output | 1 | Power-on reset, active low |
| cpu_rst_n | output | 1 | Processor reset, active low |
| pwr_fail_n | output | 1 | Power-fail warning, active low |
| irq | output | 1 | Combined unmasked interrupt |
| irq_status | output | 2 | Sticky interrupt status |
| shutdown_req | output | 1 | Latched converter shutdown request |

## Verification
The bench forces a status-bit set and its write-one-to-clear into the same clock edge. It raises the push-button, waits until the edge on which the debounced event registers, and holds `irq_clear[0]` high across that same edge. The status bit must read 1 afterwards, and a later lone clear must bring it back to 0. The bench also drops `ldo_good` while the reset pulse and the power-fail flag are high. It then checks that the power-on reset overrides both outputs in the next cycle.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;
  localparam int IRQ_W    = 2;
  localparam int IRQ_BTN  = 0;
  localparam int IRQ_COV  = 1;

  localparam int DB_N     = 3;
  localparam int DB_BTN   = 0;
  localparam int DB_HOT   = 1;
  localparam int DB_COVER = 2;

  // Counter width able to hold 0..n.
  function automatic int ctr_w(input int n);
    if (n <= 1) return 1;
    return $clog2(n + 1);
  endfunction

  // Any active warning condition pulls the power-fail flag low.
  function automatic logic fail_active(input logic por_ok, input logic vlow,
                                       input logic otemp, input logic cover_ok);
    return !por_ok || vlow || otemp || !cover_ok;
  endfunction
endpackage

// File: rtl/sup_debounce.sv
module sup_debounce
  import pwr_sup_pkg::*;
#(
  parameter int   TICKS = 16,
  parameter logic INIT  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic level,
  output logic rise,
  output logic fall
);
  localparam int             CW  = ctr_w(TICKS);
  localparam logic [CW-1:0]  LIM = CW'(TICKS - 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;
  logic          differ, accept;

  assign differ = (s2 != level);
  assign accept = tick && differ && (cnt == LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= INIT;
      s2    <= INIT;
      level <= INIT;
      cnt   <= '0;
      rise  <= 1'b0;
      fall  <= 1'b0;
    end else begin
      s1   <= raw;
      s2   <= s1;
      rise <= accept && s2;
      fall <= accept && !s2;
      if (tick) begin
        if (!differ) begin
          cnt <= '0;
        end else if (accept) begin
          level <= s2;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sup_por_timer.sv
module sup_por_timer
  import pwr_sup_pkg::*;
#(
  parameter int DELAY = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic good,
  output logic por_n
);
  localparam int            CW  = ctr_w(DELAY);
  localparam logic [CW-1:0] LIM = CW'(DELAY);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!good)       cnt <= '0;
    else if (cnt != LIM)  cnt <= cnt + 1'b1;
  end

  assign por_n = (cnt == LIM);
endmodule

// File: rtl/sup_pulse.sv
module sup_pulse
  import pwr_sup_pkg::*;
#(
  parameter int LEN = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_n,
  input  logic trig,
  output logic rst_out_n
);
  localparam int            CW  = ctr_w(LEN);
  localparam logic [CW-1:0] LIM = CW'(LEN);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             remain <= '0;
    else if (!por_n)        remain <= '0;
    else if (trig)          remain <= LIM;
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign rst_out_n = por_n && (remain == '0);
endmodule

// File: rtl/sup_irq.sv
module sup_irq
  import pwr_sup_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] set,
  input  logic [IRQ_W-1:0] clr,
  input  logic [IRQ_W-1:0] mask,
  output logic [IRQ_W-1:0] status,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr) | set;
  end

  assign irq = |(status & ~mask);
endmodule

// File: rtl/pwr_reset_sup.sv
module pwr_reset_sup
  import pwr_sup_pkg::*;
#(
  parameter int DB_TICKS  = 16,
  parameter int POR_DLY   = 1000,
  parameter int RST_PULSE = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_tick,
  input  logic             ldo_good,
  input  logic             core_in_reg,
  input  logic             vin_low,
  input  logic             overtemp_warn,
  input  logic             btn_raw,
  input  logic             hot_rst_n_raw,
  input  logic             cover_raw,
  input  logic [IRQ_W-1:0] irq_mask,
  input  logic [IRQ_W-1:0] irq_clear,
  output logic             por_n,
  output logic             cpu_rst_n,
  output logic             pwr_fail_n,
  output logic             irq,
  output logic [IRQ_W-1:0] irq_status,
  output logic             shutdown_req
);
  // Idle level per contact: button released low, hot-reset and cover high.
  localparam logic [DB_N-1:0] DB_INIT = 3'b110;

  logic [DB_N-1:0] raw_in, db_lvl, db_rise, db_fall;
  logic            btn_evt, hot_evt, cover_evt, cover_ok, pulse_trig;
  logic [IRQ_W-1:0] irq_set;

  assign raw_in = {cover_raw, hot_rst_n_raw, btn_raw};

  for (genvar i = 0; i < DB_N; i++) begin : g_db
    sup_debounce #(.TICKS(DB_TICKS), .INIT(DB_INIT[i])) u_db (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (sample_tick),
      .raw   (raw_in[i]),
      .level (db_lvl[i]),
      .rise  (db_rise[i]),
      .fall  (db_fall[i])
    );
  end

  // Named internal events, visible to the bound checker.
  assign btn_evt    = db_rise[DB_BTN];
  assign hot_evt    = db_fall[DB_HOT];
  assign cover_evt  = db_fall[DB_COVER];
  assign cover_ok   = db_lvl[DB_COVER];
  assign pulse_trig = hot_evt && core_in_reg;

  sup_por_timer #(.DELAY(POR_DLY)) u_por (
    .clk   (clk),
    .rst_n (rst_n),
    .good  (ldo_good),
    .por_n (por_n)
  );

  sup_pulse #(.LEN(RST_PULSE)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_n     (por_n),
    .trig      (pulse_trig),
    .rst_out_n (cpu_rst_n)
  );

  always_comb begin
    irq_set          = '0;
    irq_set[IRQ_BTN] = btn_evt;
    irq_set[IRQ_COV] = cover_evt;
  end

  sup_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (irq_set),
    .clr    (irq_clear),
    .mask   (irq_mask),
    .status (irq_status),
    .irq    (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shutdown_req <= 1'b0;
    else if (cover_evt) shutdown_req <= 1'b1;
  end

  assign pwr_fail_n = !fail_active(por_n, vin_low, overtemp_warn, cover_ok);
endmodule

// File: rtl/pwr_sup_chk.sv
module pwr_sup_chk
  import pwr_sup_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sample_tick,
  input logic             ldo_good,
  input logic             core_in_reg,
  input logic             por_n,
  input logic             cpu_rst_n,
  input logic             pwr_fail_n,
  input logic             shutdown_req,
  input logic             irq,
  input logic [IRQ_W-1:0] irq_status,
  input logic [IRQ_W-1:0] irq_clear,
  input logic [DB_N-1:0]  db_lvl,
  input logic [DB_N-1:0]  db_rise,
  input logic [DB_N-1:0]  db_fall,
  input logic             hot_evt,
  input logic             cover_ok
);
  a_r1_por_follows_ldo: assert property (@(posedge clk) disable iff (!rst_n)
    !ldo_good |=> !por_n);

  a_r2_cpu_held_by_por: assert property (@(posedge clk) disable iff (!rst_n)
    !por_n |-> !cpu_rst_n);

  a_r4_no_pulse_off_reg: assert property (@(posedge clk) disable iff (!rst_n)
    hot_evt && !core_in_reg && cpu_rst_n && ldo_good |=> cpu_rst_n);

  a_r5_cover_fails: assert property (@(posedge clk) disable iff (!rst_n)
    !cover_ok |-> !pwr_fail_n);

  a_r5_por_fails: assert property (@(posedge clk) disable iff (!rst_n)
    !por_n |-> !pwr_fail_n);

  a_r6_level_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(db_lvl) |-> $past(sample_tick));

  a_r6_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (|(db_rise | db_fall)) |-> $past(sample_tick));

  a_r8_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|irq_status));

  for (genvar k = 0; k < IRQ_W; k++) begin : g_sticky
    a_r9_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      irq_status[k] && !irq_clear[k] |=> irq_status[k]);
  end

  a_r10_shutdown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> shutdown_req);
endmodule

bind pwr_reset_sup pwr_sup_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample_tick  (sample_tick),
  .ldo_good     (ldo_good),
  .core_in_reg  (core_in_reg),
  .por_n        (por_n),
  .cpu_rst_n    (cpu_rst_n),
  .pwr_fail_n   (pwr_fail_n),
  .shutdown_req (shutdown_req),
  .irq          (irq),
  .irq_status   (irq_status),
  .irq_clear    (irq_clear),
  .db_lvl       (db_lvl),
  .db_rise      (db_rise),
  .db_fall      (db_fall),
  .hot_evt      (hot_evt),
  .cover_ok     (cover_ok)
);

// File: tb/pwr_reset_sup_tb.sv
`timescale 1ns/1ps
module pwr_reset_sup_tb;
  localparam int N = 3;   // debounce ticks
  localparam int D = 5;   // power-on delay
  localparam int P = 4;   // reset pulse length

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_tick = 1'b1;
  logic ldo_good = 1'b0, core_in_reg = 1'b1, vin_low = 1'b0, overtemp_warn = 1'b0;
  logic btn_raw = 1'b0, hot_rst_n_raw = 1'b1, cover_raw = 1'b1;
  logic [1:0] irq_mask = 2'b00, irq_clear = 2'b00;
  logic por_n, cpu_rst_n, pwr_fail_n, irq, shutdown_req;
  logic [1:0] irq_status;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  pwr_reset_sup #(.DB_TICKS(N), .POR_DLY(D), .RST_PULSE(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .ldo_good(ldo_good),
    .core_in_reg(core_in_reg), .vin_low(vin_low), .overtemp_warn(overtemp_warn),
    .btn_raw(btn_raw), .hot_rst_n_raw(hot_rst_n_raw), .cover_raw(cover_raw),
    .irq_mask(irq_mask), .irq_clear(irq_clear), .por_n(por_n),
    .cpu_rst_n(cpu_rst_n), .pwr_fail_n(pwr_fail_n), .irq(irq),
    .irq_status(irq_status), .shutdown_req(shutdown_req)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_err++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int lows, first;
    neg(3);
    chk("R1 reset por_n", por_n, 0);
    chk("R2 reset cpu_rst_n", cpu_rst_n, 0);
    chk("R5 reset pwr_fail_n", pwr_fail_n, 0);
    chk("R8 reset irq", irq, 0);
    chk("R9 reset status", irq_status, 0);
    chk("R10 reset shutdown", shutdown_req, 0);
    rst_n = 1'b1;
    neg(4);
    chk("R1 ldo low", por_n, 0);

    // R1 power-on delay, R2 coupling
    ldo_good = 1'b1;
    for (int k = 1; k <= D + 3; k++) begin
      neg(1);
      chk("R1 por delay", por_n, (k >= D) ? 1 : 0);
      chk("R2 cpu follows por", cpu_rst_n, (k >= D) ? 1 : 0);
    end

    // R5 sweep of comparator inputs
    for (int v = 0; v < 4; v++) begin
      vin_low = v[0]; overtemp_warn = v[1];
      #1 chk("R5 pwr_fail sweep", pwr_fail_n, (v == 0) ? 1 : 0);
      neg(1);
    end
    vin_low = 1'b0; overtemp_warn = 1'b0;

    // R6 glitches shorter than N are rejected
    for (int l = 1; l < N; l++) begin
      btn_raw = 1'b1; neg(l);
      btn_raw = 1'b0; neg(2 * N + 4);
      chk("R6 glitch rejected", irq_status, 0);
    end
    // R6 no change without ticks
    sample_tick = 1'b0;
    btn_raw = 1'b1; neg(10);
    chk("R6 no tick no change", irq_status, 0);
    btn_raw = 1'b0; neg(3);
    sample_tick = 1'b1; neg(2 * N + 4);

    // R6/R7 accept after N ticks, timing
    btn_raw = 1'b1;
    neg(N + 2);
    chk("R6 not yet accepted", irq_status[0], 0);
    neg(1);
    chk("R7 button sets status", irq_status[0], 1);
    chk("R8 unmasked irq", irq, 1);
    btn_raw = 1'b0; neg(N + 4);
    chk("R7 release sets nothing", irq_status, 2'b01);

    // R9 clear
    irq_clear = 2'b01; neg(1); irq_clear = 2'b00;
    chk("R9 clear", irq_status, 0);

    // R8 masking
    irq_mask = 2'b01;
    btn_raw = 1'b1; neg(N + 3);
    chk("R8 masked status set", irq_status[0], 1);
    chk("R8 masked irq quiet", irq, 0);
    irq_mask = 2'b00;
    #1 chk("R8 unmask raises irq", irq, 1);
    irq_clear = 2'b01; neg(1); irq_clear = 2'b00;
    btn_raw = 1'b0; neg(N + 4);

    // R9 set and clear on the same edge: set wins
    btn_raw = 1'b1; neg(N + 2);
    irq_clear = 2'b01; neg(1); irq_clear = 2'b00;
    chk("R9 set wins over clear", irq_status[0], 1);
    irq_clear = 2'b01; neg(1); irq_clear = 2'b00;
    chk("R9 lone clear", irq_status[0], 0);
    btn_raw = 1'b0; neg(N + 4);

    // R3 hot-reset pulse
    hot_rst_n_raw = 1'b0;
    lows = 0; first = 0;
    for (int j = 1; j <= N + P + 4; j++) begin
      neg(1);
      if (!cpu_rst_n) begin
        lows++;
        if (first == 0) first = j;
      end
    end
    chk("R3 pulse start", first, N + 3);
    chk("R3 pulse length", lows, P);
    hot_rst_n_raw = 1'b1; neg(N + 4);
    chk("R3 release no pulse", cpu_rst_n, 1);

    // R4 no pulse when core out of regulation
    core_in_reg = 1'b0;
    hot_rst_n_raw = 1'b0;
    lows = 0;
    for (int j = 1; j <= N + P + 4; j++) begin
      neg(1);
      if (!cpu_rst_n) lows++;
    end
    chk("R4 no pulse off regulation", lows, 0);
    hot_rst_n_raw = 1'b1; neg(N + 4);
    core_in_reg = 1'b1;

    // R5/R7/R10 battery cover removal
    cover_raw = 1'b0;
    neg(N + 1);
    chk("R5 cover not yet", pwr_fail_n, 1);
    neg(1);
    chk("R5 cover pwr_fail", pwr_fail_n, 0);
    neg(1);
    chk("R10 shutdown set", shutdown_req, 1);
    chk("R7 cover status", irq_status[1], 1);
    cover_raw = 1'b1; neg(N + 4);
    chk("R5 cover restored", pwr_fail_n, 1);
    chk("R10 shutdown sticky", shutdown_req, 1);
    chk("R7 cover close sets nothing", irq_status, 2'b10);

    // R1/R2/R5 ldo drop overrides everything
    ldo_good = 1'b0; neg(1);
    chk("R1 drop por", por_n, 0);
    chk("R2 drop cpu", cpu_rst_n, 0);
    chk("R5 drop pwr_fail", pwr_fail_n, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule